// File: doc/BRIEF.md
# Packet-Tracking Ancillary Data FIFO

This block is a single-clock word FIFO that holds ancillary data packets handed to it by an upstream filter and releases them to a host through a first-word-fall-through read port. Each packet arrives on a write port that carries start and end marks. The start word also carries the packet's declared length. While tracking is switched on, the block keeps a small circular table of packet boundaries. For each stored packet the table holds the start address, the words written so far and whether the end mark has arrived. The host can therefore tell whether at least one whole packet is waiting.

At a packet's start the block compares the declared length with the free words and checks the number of table entries in use. A packet that cannot be taken is discarded as a whole and flagged as an overrun. The host has two self-clearing commands. One empties the whole FIFO. The other throws away the oldest stored packet. Each command waits in a pending state until the ports are quiet. The host also sees empty, full, a 90%-full early warning and a sticky overrun indication.

Top module: `anc_pkt_fifo`

## Requirements
- R1: After reset, empty is 1 and full, almost_full, overrun, pkt_avail, flush_all_busy and flush_old_busy are all 0.
- R2: Words leave in the order they were stored. rd_data always shows the oldest stored word. A rd_en pulse while empty changes nothing.
- R3: full is 1 exactly when DEPTH words are held. With tracking off, a write while full stores nothing and sets overrun, which stays 1 until a flush-all runs.
- R4: almost_full is 1 when occupancy is at least ceil(0.9 × DEPTH), which is 231 for the default depth of 256, and 0 below that.
- R5: With tracking on, pkt_avail is 1 while at least one packet whose end mark (wr_eop=1) has been stored is still unread. It is 0 while only part of a packet is present.
- R6: With tracking on, a start word (wr_sop=1) whose wr_len is 0 or exceeds the free words drops that word and every word up to its end mark, stores nothing and sets overrun.
- R7: With tracking on and MAX_PKTS (8) packets already in the table, a new start word is rejected like R6 and sets overrun.
- R8: A flush_all_req pulse sets flush_all_busy. In the first cycle with no wr_valid, no rd_en and no open packet, the FIFO empties, overrun clears and flush_all_busy returns to 0.
- R9: A flush_old_req pulse sets flush_old_busy. In the first cycle with no wr_valid, no rd_en and no open packet, the unread words of the oldest tracked packet are discarded and flush_old_busy returns to 0. While a packet is still open, the command waits.
- R10: Reading the last word of the oldest complete packet removes it from the table, so pkt_avail falls when no other complete packet remains.
- R11: With tracking off, the table is cleared and pkt_avail is 0. Every word is stored on its own, whatever its start and end marks, and empty, full, almost_full and overrun keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| track_en | input | 1 | Packet tracking enable |
| wr_valid | input | 1 | Write strobe |
| wr_sop | input | 1 | First word of a packet |
| wr_eop | input | 1 | Last word of a packet |
| wr_len | input | $clog2(DEPTH)+1 | Declared packet length, sampled with wr_sop |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read strobe, pops rd_data |
| rd_data | output | DATA_W | Oldest stored word |
| flush_all_req | input | 1 | Pulse: empty the FIFO |
| flush_old_req | input | 1 | Pulse: drop the oldest packet |
| flush_all_busy | output | 1 | Flush-all pending |
| flush_old_busy | output | 1 | Flush-oldest pending |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |
| almost_full | output | 1 | Occupancy at or above the 90% level |
| overrun | output | 1 | Sticky: a word or packet was refused |
| pkt_avail | output | 1 | At least one complete packet stored |

## Verification
The packet path is driven with one packet split around a pause, so a partial packet can be told apart from a complete one. It is also driven with back-to-back multi-word packets, where flush-oldest must skip exactly the first packet, and with runs of one-word packets that fill the boundary table. An oversized declared length checks that rejection happens before any word is stored. With tracking off, a stream of unmarked words fills the FIFO up to the warning level, then to full, then one word past full. This separates the occupancy flags from the packet logic and also carries the data order across most of the address range. The flush commands are raised during port activity, which shows that they wait until the ports are quiet.

// File: rtl/anc_fifo_pkg.sv
package anc_fifo_pkg;

    // outcome of a start-of-packet word
    typedef enum logic [1:0] {
        SOP_NONE,
        SOP_TAKE,
        SOP_REJECT
    } sop_act_e;

    // smallest occupancy that is at least 90 percent of depth
    function automatic int af_level(input int depth);
        return (9 * depth + 9) / 10;
    endfunction

endpackage

// File: rtl/anc_fifo_ram.sv
module anc_fifo_ram #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/anc_pkt_table.sv
module anc_pkt_table #(
    parameter int PTR_W    = 8,
    parameter int LEN_W    = 9,
    parameter int MAX_PKTS = 8,
    localparam int IDX_W   = $clog2(MAX_PKTS),
    localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [PTR_W-1:0] push_start,
    input  logic             push_done,
    input  logic             grow,
    input  logic             close,
    input  logic             pop,
    output logic [CNT_W-1:0] n_ent,
    output logic [PTR_W-1:0] head_start,
    output logic [LEN_W-1:0] head_len,
    output logic             head_done,
    output logic             any_done,
    output logic             tbl_full
);

    typedef struct packed {
        logic [MAX_PKTS-1:0][PTR_W-1:0] start;
        logic [MAX_PKTS-1:0][LEN_W-1:0] len;
        logic [MAX_PKTS-1:0]            done;
        logic [IDX_W-1:0]               head;
        logic [IDX_W-1:0]               tail;
        logic [CNT_W-1:0]               n_ent;
        logic [CNT_W-1:0]               n_done;
    } tbl_t;

    tbl_t t_d, t_q;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        t_d      = t_q;
        last_idx = t_q.tail - 1'b1;
        if (clear) begin
            t_d = '0;
        end else begin
            if (grow) begin
                t_d.len[last_idx] = t_q.len[last_idx] + 1'b1;
            end
            if (close) begin
                t_d.done[last_idx] = 1'b1;
            end
            if (push) begin
                t_d.start[t_q.tail] = push_start;
                t_d.len[t_q.tail]   = LEN_W'(1);
                t_d.done[t_q.tail]  = push_done;
                t_d.tail            = t_q.tail + 1'b1;
            end
            if (pop) begin
                t_d.done[t_q.head] = 1'b0;
                t_d.head           = t_q.head + 1'b1;
            end
            t_d.n_ent  = t_q.n_ent + CNT_W'(push) - CNT_W'(pop);
            t_d.n_done = t_q.n_done + CNT_W'(push && push_done)
                       + CNT_W'(close) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign n_ent      = t_q.n_ent;
    assign head_start = t_q.start[t_q.head];
    assign head_len   = t_q.len[t_q.head];
    assign head_done  = t_q.done[t_q.head];
    assign any_done   = (t_q.n_done != '0);
    assign tbl_full   = (t_q.n_ent == CNT_W'(MAX_PKTS));

    // R7: never more than MAX_PKTS tracked packets
    a_r7_table_bound: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.n_ent <= CNT_W'(MAX_PKTS));

    // R10: only a finished packet is ever removed
    a_r10_pop_done: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> head_done);

    // R5: complete packets are a subset of tracked packets
    a_r5_done_le_ent: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.n_done <= t_q.n_ent);

endmodule

// File: rtl/anc_pkt_fifo.sv
module anc_pkt_fifo
    import anc_fifo_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int DEPTH    = 256,
    parameter int MAX_PKTS = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1,
    localparam int TCW     = $clog2(MAX_PKTS + 1),
    localparam int AF_LVL  = af_level(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_en,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [CW-1:0]     wr_len,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              flush_all_req,
    input  logic              flush_old_req,
    output logic              flush_all_busy,
    output logic              flush_old_busy,
    output logic              empty,
    output logic              full,
    output logic              almost_full,
    output logic              overrun,
    output logic              pkt_avail
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        logic [CW-1:0] head_rd;
        logic          in_pkt;
        logic          drop;
        logic          ovr;
        logic          fa_pend;
        logic          fo_pend;
    } st_t;

    st_t s_d, s_q;

    sop_act_e       sop_act;
    logic           wr_store, ovr_set, rd_acc, quiet, fa_go, fo_go;
    logic           push, grow, close, pop, clear_tbl, head_at;
    logic [CW-1:0]  free;
    logic [TCW-1:0] n_ent;
    logic [AW-1:0]  head_start;
    logic [CW-1:0]  head_len;
    logic           head_done, any_done, tbl_full, is_full;

    assign is_full = (s_q.count == CW'(DEPTH));

    always_comb begin
        s_d      = s_q;
        sop_act  = SOP_NONE;
        wr_store = 1'b0;
        ovr_set  = 1'b0;
        push     = 1'b0;
        grow     = 1'b0;
        close    = 1'b0;
        pop      = 1'b0;
        free     = CW'(DEPTH) - s_q.count;
        rd_acc   = rd_en && (s_q.count != '0);
        quiet    = !wr_valid && !rd_en && !s_q.in_pkt;
        fa_go    = s_q.fa_pend && quiet;
        fo_go    = s_q.fo_pend && quiet && !fa_go;
        head_at  = (n_ent != '0) && (s_q.rptr == head_start + AW'(s_q.head_rd));

        // write side
        if (wr_valid) begin
            if (!track_en) begin
                if (is_full) ovr_set = 1'b1;
                else         wr_store = 1'b1;
            end else if (wr_sop) begin
                sop_act = (wr_len != '0 && wr_len <= free && !tbl_full)
                        ? SOP_TAKE : SOP_REJECT;
                close = s_q.in_pkt;   // a short packet is closed as it stands
                if (sop_act == SOP_TAKE) begin
                    wr_store   = 1'b1;
                    push       = 1'b1;
                    s_d.in_pkt = !wr_eop;
                    s_d.drop   = 1'b0;
                end else begin
                    ovr_set    = 1'b1;
                    s_d.in_pkt = 1'b0;
                    s_d.drop   = !wr_eop;
                end
            end else if (s_q.drop) begin
                s_d.drop = !wr_eop;
            end else if (s_q.in_pkt) begin
                if (is_full) begin
                    ovr_set = 1'b1;
                end else begin
                    wr_store = 1'b1;
                    grow     = 1'b1;
                end
                if (wr_eop) begin
                    close      = 1'b1;
                    s_d.in_pkt = 1'b0;
                end
            end
        end

        if (wr_store) s_d.wptr = s_q.wptr + 1'b1;
        if (rd_acc)   s_d.rptr = s_q.rptr + 1'b1;
        s_d.count = s_q.count + CW'(wr_store) - CW'(rd_acc);

        // follow reads through the oldest tracked packet
        if (track_en && rd_acc && head_at) begin
            if (head_done && (s_q.head_rd + 1'b1 == head_len)) begin
                pop         = 1'b1;
                s_d.head_rd = '0;
            end else begin
                s_d.head_rd = s_q.head_rd + 1'b1;
            end
        end

        // drop the oldest packet
        if (fo_go && track_en && n_ent != '0) begin
            s_d.rptr    = head_start + AW'(head_len);
            s_d.count   = s_q.count - (head_len - s_q.head_rd);
            s_d.head_rd = '0;
            pop         = 1'b1;
        end

        s_d.ovr     = fa_go ? 1'b0 : (s_q.ovr || ovr_set);
        s_d.fa_pend = (s_q.fa_pend || flush_all_req) && !fa_go;
        s_d.fo_pend = (s_q.fo_pend || flush_old_req) && !fo_go;

        if (fa_go) begin
            s_d.wptr    = '0;
            s_d.rptr    = '0;
            s_d.count   = '0;
            s_d.head_rd = '0;
            s_d.in_pkt  = 1'b0;
            s_d.drop    = 1'b0;
        end
        if (!track_en) begin
            s_d.in_pkt  = 1'b0;
            s_d.drop    = 1'b0;
            s_d.head_rd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clear_tbl = fa_go || !track_en;

    anc_fifo_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (wr_store),
        .waddr (s_q.wptr),
        .wdata (wr_data),
        .raddr (s_q.rptr),
        .rdata (rd_data)
    );

    anc_pkt_table #(
        .PTR_W    (AW),
        .LEN_W    (CW),
        .MAX_PKTS (MAX_PKTS)
    ) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_tbl),
        .push       (push),
        .push_start (s_q.wptr),
        .push_done  (wr_eop),
        .grow       (grow),
        .close      (close),
        .pop        (pop),
        .n_ent      (n_ent),
        .head_start (head_start),
        .head_len   (head_len),
        .head_done  (head_done),
        .any_done   (any_done),
        .tbl_full   (tbl_full)
    );

    assign empty          = (s_q.count == '0);
    assign full           = is_full;
    assign almost_full    = (s_q.count >= CW'(AF_LVL));
    assign overrun        = s_q.ovr;
    assign pkt_avail      = any_done && track_en;
    assign flush_all_busy = s_q.fa_pend;
    assign flush_old_busy = s_q.fo_pend;

    // R3: occupancy never exceeds depth
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));

    // R3: untracked write into a full FIFO raises overrun
    a_r3_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !track_en && full) |=> overrun);

    // R2: a read of an empty FIFO leaves it empty
    a_r2_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_valid && !flush_old_busy) |=> empty);

    // R8: a quiet cycle with flush pending leaves an empty, clean FIFO
    a_r8_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all_busy && !wr_valid && !rd_en && !s_q.in_pkt && !flush_all_req)
        |=> (empty && !overrun && !flush_all_busy));

    // R9: flush-oldest completes in the first quiet cycle
    a_r9_flush_old: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_old_busy && !flush_all_busy && !wr_valid && !rd_en
         && !s_q.in_pkt && !flush_old_req) |=> !flush_old_busy);

    // R5: a complete packet means stored words
    a_r5_avail_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_avail |-> !empty);

endmodule

// File: tb/anc_pkt_fifo_tb.sv
`timescale 1ns/1ps
module anc_pkt_fifo_tb;

    localparam int DATA_W = 10;
    localparam int DEPTH  = 256;
    localparam int CW     = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              track_en = 1'b0;
    logic              wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [CW-1:0]     wr_len = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              flush_all_req = 1'b0, flush_old_req = 1'b0;
    logic              flush_all_busy, flush_old_busy;
    logic              empty, full, almost_full, overrun, pkt_avail;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [DATA_W-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    anc_pkt_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .track_en(track_en),
        .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .wr_len(wr_len), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .flush_all_req(flush_all_req), .flush_old_req(flush_old_req),
        .flush_all_busy(flush_all_busy), .flush_old_busy(flush_old_busy),
        .empty(empty), .full(full), .almost_full(almost_full),
        .overrun(overrun), .pkt_avail(pkt_avail)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: one write cycle; keep=1 pushes the word to the scoreboard
    task automatic put(input int d, input logic s, input logic e,
                       input int len, input bit keep);
        wr_valid = 1'b1; wr_sop = s; wr_eop = e;
        wr_len = CW'(len); wr_data = DATA_W'(d);
        @(negedge clk);
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
        if (keep) exp_q.push_back(DATA_W'(d));
    endtask

    // monitor: compare the presented word with the scoreboard, then pop it
    task automatic take(input string tag);
        logic [DATA_W-1:0] e;
        if (exp_q.size() == 0) begin
            chk(0, 1, {tag, " scoreboard underflow"});
        end else begin
            e = exp_q.pop_front();
            chk(int'(rd_data), int'(e), tag);
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(2);
        // R1 reset state
        chk(empty, 1, "R1 empty");       chk(full, 0, "R1 full");
        chk(almost_full, 0, "R1 af");    chk(overrun, 0, "R1 overrun");
        chk(pkt_avail, 0, "R1 avail");   chk(flush_all_busy, 0, "R1 fa_busy");
        chk(flush_old_busy, 0, "R1 fo_busy");
        rst_n = 1'b1;
        track_en = 1'b1;
        idle(1);

        // R5 partial then complete, R2 order, R10 consumption
        put(11, 1, 0, 4, 1); put(12, 0, 0, 0, 1);
        idle(1);
        chk(pkt_avail, 0, "R5 partial packet");
        put(13, 0, 0, 0, 1); put(14, 0, 1, 0, 1);
        chk(pkt_avail, 1, "R5 complete packet");
        for (int i = 0; i < 4; i++) take("R2 packet order");
        chk(pkt_avail, 0, "R10 consumed packet");
        chk(empty, 1, "R10 empty after read");
        rd_en = 1'b1; idle(1); rd_en = 1'b0;
        chk(empty, 1, "R2 read when empty");
        chk(overrun, 0, "R2 read when empty no overrun");

        // R9 flush-oldest, deferred while a packet is open
        put(21, 1, 0, 3, 0); put(22, 0, 0, 0, 0); put(23, 0, 1, 0, 0);
        put(31, 1, 0, 2, 1); put(32, 0, 1, 0, 1);
        put(41, 1, 0, 2, 1);
        flush_old_req = 1'b1; idle(1); flush_old_req = 1'b0;
        chk(flush_old_busy, 1, "R9 pending");
        put(42, 0, 1, 0, 1);
        chk(flush_old_busy, 1, "R9 deferred during write");
        idle(1);
        chk(flush_old_busy, 0, "R9 self clear");
        for (int i = 0; i < 4; i++) take("R9 oldest dropped");
        chk(empty, 1, "R9 empty after");

        // R6 oversized packet dropped whole
        put(51, 1, 0, 300, 0); put(52, 0, 0, 0, 0); put(53, 0, 1, 0, 0);
        chk(overrun, 1, "R6 overrun set");
        chk(empty, 1, "R6 nothing stored");
        chk(pkt_avail, 0, "R6 no packet");

        // R8 flush-all deferred by a write, then clears
        flush_all_req = 1'b1;
        put(61, 1, 1, 1, 0);
        flush_all_req = 1'b0;
        chk(flush_all_busy, 1, "R8 pending");
        chk(empty, 0, "R8 deferred write kept");
        idle(1);
        chk(flush_all_busy, 0, "R8 self clear");
        chk(empty, 1, "R8 emptied");
        chk(overrun, 0, "R8 overrun cleared");

        // R7 table limit
        for (int i = 0; i < 8; i++) put(70 + i, 1, 1, 1, 1);
        chk(overrun, 0, "R7 eight accepted");
        put(99, 1, 1, 1, 0);
        chk(overrun, 1, "R7 ninth rejected");
        chk(pkt_avail, 1, "R7 avail");
        for (int i = 0; i < 8; i++) take("R7 stored packets");
        chk(empty, 1, "R7 ninth not stored");
        chk(pkt_avail, 0, "R10 all consumed");
        flush_all_req = 1'b1; idle(1); flush_all_req = 1'b0; idle(1);
        chk(overrun, 0, "R8 overrun cleared again");

        // R11 tracking off clears the table
        put(81, 1, 1, 1, 1);
        chk(pkt_avail, 1, "R11 avail before");
        track_en = 1'b0; idle(1);
        chk(pkt_avail, 0, "R11 avail off");
        chk(empty, 0, "R11 data kept");
        take("R11 data after off");

        // R4 / R3 fill with tracking off, words unmarked
        for (int i = 0; i < 230; i++) put(100 + i, 0, 0, 0, 1);
        chk(almost_full, 0, "R4 below level 230");
        put(330, 0, 0, 0, 1);
        chk(almost_full, 1, "R4 at level 231");
        for (int i = 231; i < 255; i++) put(100 + i, 0, 0, 0, 1);
        chk(full, 0, "R3 not full at 255");
        put(355, 0, 0, 0, 1);
        chk(full, 1, "R3 full at 256");
        chk(overrun, 0, "R3 no overrun yet");
        put(999, 0, 0, 0, 0);
        chk(overrun, 1, "R3 overrun on full write");
        chk(pkt_avail, 0, "R11 avail stays off");
        for (int i = 0; i < 256; i++) take("R2 fill order");
        chk(empty, 1, "R3 drained");
        chk(overrun, 1, "R3 overrun sticky");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule